// File: doc/BRIEF.md
# Ready-Line Watchdog with Channel Control Register

This block supervises the device ready handshake line of one storage channel during programmed-I/O transfers. While the watchdog is enabled, ready monitoring is on, a PIO transfer is in progress and the device holds ready low, a counter advances once per clock. If ready stays low for 256 counted clocks, a sticky timeout flag is set. The transfer itself is never stalled or aborted. From that point the block stops looking at the ready line until software clears the flag by writing a one to it, which arms the watchdog again.

A 16-bit control/status word holds the enables, the timeout flag and a channel reset control. It is written through a simple port with two byte-lane strobes and read back combinationally. The interrupt request is the timeout flag gated by its enable. The channel reset output follows its control bit for as long as that bit is set.

Top module: `ready_watchdog`

## Requirements
- R1: After reset the read value is 0x0001, timeoutIrq and channelRst are low, the counter is zero and monitoring is armed.
- R2: Lane strobe regWrStrb[1] writes bits 15:8 (bit 14 = interrupt enable, bit 13 = watchdog enable, bit 12 = clear-on-one). Lane strobe regWrStrb[0] writes bits 7:0 (bit 2 = channel reset). Bits in a lane whose strobe is low keep their value.
- R3: Bits 15, 10, 9 to 3 and 1 read as zero and bit 0 reads as one. Bit 11 reads the present value of timeoutIrq.
- R4: The counter advances only when the watchdog enable is set, monitorEn is high, pioActive is high and readyLine is low.
- R5: The timeout flag (read bit 12) is set on the 256th consecutive counting clock edge and not before.
- R6: When any counting condition drops before expiry, the counter returns to zero, so a later low period counts from zero.
- R7: While the flag is set the ready line is ignored and the counter stays at zero.
- R8: Writing one to bit 12 with lane 1 strobed clears the flag. Writing zero has no effect. After a clear, counting restarts from zero on the next edge.
- R9: timeoutIrq is high exactly when the flag and the interrupt enable are both set.
- R10: If expiry and a clear-on-one write fall on the same edge, the flag ends up set.
- R11: channelRst equals control bit 2 and stays asserted while that bit is one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| readyLine | input | 1 | Device ready handshake, high = ready |
| pioActive | input | 1 | High while a programmed-I/O transfer runs |
| monitorEn | input | 1 | Ready monitoring enable |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 16 | Register write data |
| regWrStrb | input | 2 | Byte-lane strobes, bit 1 = upper byte |
| regRdData | output | 16 | Control/status read value |
| timeoutIrq | output | 1 | Timeout interrupt request |
| channelRst | output | 1 | Channel reset output |

## Verification
Register writes take effect on the clock edge that samples them, and the read value, interrupt and reset outputs decode the stored state without further registers, so they are due 1 ns after that edge. The timeout flag appears on the 256th counting edge. The bench counts edges exactly, checks after edge 255 that the flag is still clear, then checks after edge 256 that it is set. Every sample is taken 1 ns after a rising edge, and inputs change at the same point, so no check is made on the edge itself.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  typedef struct packed {
    logic cntInc;
    logic cntClr;
    logic flagSet;
    logic flagClr;
    logic loadHi;
    logic loadLo;
  } wdStrobes_t;
endpackage

// File: rtl/wdog_control.sv
module wdog_control
  import wdog_pkg::*;
(
  input  logic       readyLine,
  input  logic       pioActive,
  input  logic       monitorEn,
  input  logic       regWrEn,
  input  logic [1:0] regWrStrb,
  input  logic       clearBit,
  input  logic       wdEnQ,
  input  logic       flagQ,
  input  logic       cntAtLast,
  output wdStrobes_t strobes
);
  logic watching;

  always_comb begin
    watching        = wdEnQ && monitorEn && pioActive && !readyLine && !flagQ;
    strobes.cntInc  = watching && !cntAtLast;
    strobes.flagSet = watching && cntAtLast;
    strobes.cntClr  = !watching || cntAtLast;
    strobes.loadHi  = regWrEn && regWrStrb[1];
    strobes.loadLo  = regWrEn && regWrStrb[0];
    // hardware set takes priority over a software clear in the same cycle
    strobes.flagClr = strobes.loadHi && clearBit && !strobes.flagSet;
  end
endmodule

// File: rtl/wdog_datapath.sv
module wdog_datapath
  import wdog_pkg::*;
#(
  parameter int LIMIT = 256,
  localparam int CNT_W = $clog2(LIMIT)
) (
  input  logic             clk,
  input  logic             rstN,
  input  wdStrobes_t       strobes,
  input  logic [15:0]      regWrData,
  output logic             wdEnQ,
  output logic             flagQ,
  output logic             cntAtLast,
  output logic [CNT_W-1:0] count,
  output logic [15:0]      regRdData,
  output logic             timeoutIrq,
  output logic             channelRst
);
  logic irqEnQ;
  logic rstQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= '0;
    end else if (strobes.cntClr) begin
      count <= '0;
    end else if (strobes.cntInc) begin
      count <= count + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqEnQ <= 1'b0;
      wdEnQ  <= 1'b0;
      rstQ   <= 1'b0;
      flagQ  <= 1'b0;
    end else begin
      if (strobes.loadHi) begin
        irqEnQ <= regWrData[14];
        wdEnQ  <= regWrData[13];
      end
      if (strobes.loadLo) begin
        rstQ <= regWrData[2];
      end
      if (strobes.flagSet) begin
        flagQ <= 1'b1;
      end else if (strobes.flagClr) begin
        flagQ <= 1'b0;
      end
    end
  end

  always_comb begin
    cntAtLast  = (count == CNT_W'(LIMIT - 1));
    timeoutIrq = flagQ && irqEnQ;
    channelRst = rstQ;
    regRdData  = {1'b0, irqEnQ, wdEnQ, flagQ, timeoutIrq, 1'b0,
                  7'b0, rstQ, 1'b0, 1'b1};
  end
endmodule

// File: rtl/ready_watchdog.sv
module ready_watchdog
  import wdog_pkg::*;
#(
  parameter int LIMIT = 256,
  localparam int CNT_W = $clog2(LIMIT)
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        readyLine,
  input  logic        pioActive,
  input  logic        monitorEn,
  input  logic        regWrEn,
  input  logic [15:0] regWrData,
  input  logic [1:0]  regWrStrb,
  output logic [15:0] regRdData,
  output logic        timeoutIrq,
  output logic        channelRst
);
  wdStrobes_t       strobes;
  logic             wdEnQ;
  logic             flagQ;
  logic             cntAtLast;
  logic [CNT_W-1:0] wdCount;

  wdog_control ctrl (
    .readyLine (readyLine),
    .pioActive (pioActive),
    .monitorEn (monitorEn),
    .regWrEn   (regWrEn),
    .regWrStrb (regWrStrb),
    .clearBit  (regWrData[12]),
    .wdEnQ     (wdEnQ),
    .flagQ     (flagQ),
    .cntAtLast (cntAtLast),
    .strobes   (strobes)
  );

  wdog_datapath #(.LIMIT(LIMIT)) dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .regWrData  (regWrData),
    .wdEnQ      (wdEnQ),
    .flagQ      (flagQ),
    .cntAtLast  (cntAtLast),
    .count      (wdCount),
    .regRdData  (regRdData),
    .timeoutIrq (timeoutIrq),
    .channelRst (channelRst)
  );
endmodule

// File: rtl/ready_watchdog_checker.sv
module ready_watchdog_checker #(
  parameter int LIMIT = 256,
  localparam int CNT_W = $clog2(LIMIT)
) (
  input logic             clk,
  input logic             rstN,
  input logic             readyLine,
  input logic             regWrEn,
  input logic [15:0]      regWrData,
  input logic [1:0]       regWrStrb,
  input logic [15:0]      regRdData,
  input logic             timeoutIrq,
  input logic             channelRst,
  input logic [CNT_W-1:0] wdCount
);
  assert_reserved_R3: assert property (@(posedge clk) disable iff (!rstN)
    regRdData[15] == 1'b0 && regRdData[10:3] == 8'b0 && regRdData[1] == 1'b0 && regRdData[0]);

  assert_irq_status_R3: assert property (@(posedge clk) disable iff (!rstN)
    regRdData[11] == timeoutIrq);

  assert_irq_gated_R9: assert property (@(posedge clk) disable iff (!rstN)
    timeoutIrq |-> (regRdData[14] && regRdData[12]));

  assert_rst_follows_R11: assert property (@(posedge clk) disable iff (!rstN)
    channelRst == regRdData[2]);

  assert_restart_R6: assert property (@(posedge clk) disable iff (!rstN)
    readyLine |=> (wdCount == '0));

  assert_expiry_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(regRdData[12]) |-> ($past(wdCount) == CNT_W'(LIMIT - 1)));

  assert_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    (regRdData[12] && !(regWrEn && regWrStrb[1] && regWrData[12])) |=> regRdData[12]);

  assert_frozen_R7: assert property (@(posedge clk) disable iff (!rstN)
    regRdData[12] |=> (wdCount == '0));
endmodule

bind ready_watchdog ready_watchdog_checker #(.LIMIT(LIMIT)) chk (
  .clk        (clk),
  .rstN       (rstN),
  .readyLine  (readyLine),
  .regWrEn    (regWrEn),
  .regWrData  (regWrData),
  .regWrStrb  (regWrStrb),
  .regRdData  (regRdData),
  .timeoutIrq (timeoutIrq),
  .channelRst (channelRst),
  .wdCount    (wdCount)
);

// File: tb/ready_watchdog_test.sv
`timescale 1ns/1ps
module ready_watchdog_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        readyLine = 1'b1;
  logic        pioActive = 1'b0;
  logic        monitorEn = 1'b0;
  logic        regWrEn = 1'b0;
  logic [15:0] regWrData = '0;
  logic [1:0]  regWrStrb = '0;
  logic [15:0] regRdData;
  logic        timeoutIrq;
  logic        channelRst;

  int totalCnt = 0;
  int failCnt  = 0;

  always #5 clk = ~clk;

  ready_watchdog uut (
    .clk(clk), .rstN(rstN), .readyLine(readyLine), .pioActive(pioActive),
    .monitorEn(monitorEn), .regWrEn(regWrEn), .regWrData(regWrData),
    .regWrStrb(regWrStrb), .regRdData(regRdData), .timeoutIrq(timeoutIrq),
    .channelRst(channelRst)
  );

  // {strobes, write data, expected read value}; no counting during the table
  localparam int NVEC = 7;
  localparam logic [33:0] VEC [NVEC] = '{
    {2'b11, 16'h6004, 16'h6005},
    {2'b01, 16'h0000, 16'h6001},
    {2'b10, 16'h0000, 16'h0001},
    {2'b11, 16'hFFFF, 16'h6005},
    {2'b00, 16'h0000, 16'h6005},
    {2'b10, 16'h2000, 16'h2005},
    {2'b01, 16'h0000, 16'h2001}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    totalCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [1:0] strb, input logic [15:0] data);
    regWrEn = 1'b1;
    regWrStrb = strb;
    regWrData = data;
    step(1);
    regWrEn = 1'b0;
    regWrStrb = 2'b00;
    regWrData = '0;
  endtask

  initial begin
    #2_000_000;
    totalCnt++;
    failCnt++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", totalCnt - failCnt, totalCnt);
    $finish;
  end

  initial begin
    step(3);
    rstN = 1'b1;
    check("R1 read", regRdData, 16'h0001);
    check("R1 irq", {15'b0, timeoutIrq}, 16'h0);
    check("R1 rst", {15'b0, channelRst}, 16'h0);

    for (int i = 0; i < NVEC; i++) begin
      wr(VEC[i][33:32], VEC[i][31:16]);
      check("R2/R3 vector read", regRdData, VEC[i][15:0]);
      check("R11 vector rst", {15'b0, channelRst}, {15'b0, VEC[i][2]});
    end

    // R4: no counting without monitorEn, then without pioActive
    wr(2'b10, 16'h6000);
    readyLine = 1'b0; pioActive = 1'b1; monitorEn = 1'b0;
    step(300);
    check("R4 monitor off", regRdData, 16'h6001);
    monitorEn = 1'b1; pioActive = 1'b0;
    step(300);
    check("R4 pio off", regRdData, 16'h6001);

    // R5: expiry on the 256th counting edge
    pioActive = 1'b1;
    step(255);
    check("R5 edge 255", regRdData, 16'h6001);
    step(1);
    check("R5 edge 256", regRdData, 16'h7801);
    check("R9 irq on", {15'b0, timeoutIrq}, 16'h1);

    // R7: ready ignored after expiry
    readyLine = 1'b1; step(5); readyLine = 1'b0; step(300);
    check("R7 flag held", regRdData, 16'h7801);

    // R8: write zero has no effect; R2: lane 0 cannot touch bit 12
    wr(2'b10, 16'h6000);
    check("R8 zero write", regRdData, 16'h7801);
    wr(2'b01, 16'h1000);
    check("R2 lane0 w1c", regRdData, 16'h7801);

    // R9: gating by interrupt enable
    wr(2'b10, 16'h2000);
    check("R9 gated read", regRdData, 16'h3001);
    check("R9 gated irq", {15'b0, timeoutIrq}, 16'h0);
    wr(2'b10, 16'h6000);
    check("R9 regated irq", {15'b0, timeoutIrq}, 16'h1);

    // R8: clear re-arms and counts from zero
    wr(2'b10, 16'h7000);
    check("R8 cleared", regRdData, 16'h6001);
    check("R8 irq low", {15'b0, timeoutIrq}, 16'h0);
    step(255);
    check("R8 rearm edge 255", regRdData, 16'h6001);
    step(1);
    check("R8 rearm edge 256", regRdData, 16'h7801);

    // R6: ready pulse restarts the count
    wr(2'b10, 16'h7000);
    step(200);
    readyLine = 1'b1; step(1); readyLine = 1'b0;
    step(255);
    check("R6 restart edge 255", regRdData, 16'h6001);
    step(1);
    check("R6 restart edge 256", regRdData, 16'h7801);

    // R10: set and clear on the same edge
    wr(2'b10, 16'h7000);
    step(255);
    wr(2'b10, 16'h7000);
    check("R10 set wins", regRdData, 16'h7801);

    // R4: watchdog enable off
    wr(2'b10, 16'h5000);
    check("R4 wd off clear", regRdData, 16'h4001);
    step(300);
    check("R4 wd off", regRdData, 16'h4001);

    // R11: channel reset held
    wr(2'b01, 16'h0004);
    step(10);
    check("R11 rst held", {15'b0, channelRst}, 16'h1);
    wr(2'b01, 16'h0000);
    check("R11 rst off", {15'b0, channelRst}, 16'h0);

    $display("%0d/%0d checks passed", totalCnt - failCnt, totalCnt);
    $finish;
  end
endmodule